// File: doc/BRIEF.md
# Latched Loss-of-Signal Interrupt Controller

This block holds the per-channel loss-of-signal status and the related controls of a four-lane optical receive/transmit end. Each channel's raw loss indication (an asynchronous level from the analog front end) passes through a synchronizer. It then sets a sticky flag. The flag stays set until the host reads the flag byte through the register slave, and that read strobe clears it. Unmasked flags pull an active-low interrupt line low, for an open-drain pad. The same line level can be read back as a soft status bit.

The block also holds the per-channel transmit-disable bits and the receive-squelch-disable bits. It drives a squelch request for each channel while that channel's loss condition is present, unless squelch is disabled for it. Register access comes from an external byte-wide slave through a page number, a byte address, a write strobe, a read strobe and combinational read data. Addresses below 128 ignore the page number. Addresses of 128 and above are decoded together with the page.

Top module: `los_irq_ctrl`

## Requirements
- R1: A raw loss input held high sets bit i (channel i, bits 0 to 3) of lower byte 3 exactly three clock edges after it is first sampled.
- R2: A set flag bit stays set after its raw input falls, as long as no read strobe addresses lower byte 3.
- R3: A read strobe on lower byte 3 returns the current flags and clears them at that clock edge. A channel whose synchronized raw input is still high stays set.
- R4: int_n goes low one edge after any flag is set whose mask bit is 0. It goes high one edge after no such flag remains.
- R5: Mask bits are bits 0 to 3 of lower byte 100. They reset to 0. A masked flag still latches but never pulls int_n low.
- R6: Lower byte 2 reads bit 1 equal to the present int_n level, and all its other bits read 0.
- R7: Transmit-disable bits are bits 0 to 3 of lower byte 86. They reset to 0, are readable and writable, and drive tx_disable directly. Bits 4 to 7 of byte 86 read 0.
- R8: Squelch-disable bits are bits 4 to 7 of byte 240 on page 3, and they reset to 0. Byte 240 on any other page reads 0, and writes to it there are ignored.
- R9: rx_squelch[i] is high three edges after raw input i is sampled high, provided squelch-disable bit i is 0. It is low whenever that bit is 1.
- R10: Writes to lower bytes 2 and 3 have no effect. Read strobes to addresses other than lower byte 3 do not clear flags.
- R11: After reset, all flags, masks, transmit-disable bits, squelch-disable bits and squelch outputs are 0, and int_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_raw | input | 4 | Raw loss-of-signal level per channel, asynchronous |
| acc_page | input | 8 | Page number for addresses 128 and above |
| acc_addr | input | 8 | Byte address |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_rd | input | 1 | Read strobe, one cycle, used for clear-on-read |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Combinational read data for the addressed byte |
| int_n | output | 1 | Active-low interrupt, drive-low request for an open-drain pad |
| tx_disable | output | 4 | Per-channel transmit disable |
| rx_squelch | output | 4 | Per-channel receive-output squelch request |

## Verification
A flag register that loses or invents a bit shows up in the byte 3 read value and in int_n within one edge of the fault. A mask or clear fault shows as an int_n level that does not match the flag byte, seen one edge later. Squelch-disable or transmit-disable storage faults show directly on rx_squelch and tx_disable, and in the read-back of bytes 240 and 86. The sweeps run every loss pattern against every mask pattern and every squelch-disable pattern. A single stuck or swapped bit therefore differs from the expected value in the same cycle it is checked.

// File: rtl/los_irq_pkg.sv
package los_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int MAX_CH = 4;
  localparam logic [7:0] ADDR_STATUS = 8'd2;
  localparam logic [7:0] ADDR_FLAGS  = 8'd3;
  localparam logic [7:0] ADDR_TXDIS  = 8'd86;
  localparam logic [7:0] ADDR_MASK   = 8'd100;
  localparam logic [7:0] ADDR_SQDIS  = 8'd240;
  localparam logic [7:0] PAGE_SQDIS  = 8'd3;
  localparam int STATUS_INT_BIT = 1;
  localparam int SQDIS_LSB = 4;
endpackage

// File: rtl/los_sync.sv
module los_sync #(
  parameter int NUM_CH = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] sync_o
);
  logic [STAGES-1:0][NUM_CH-1:0] chain_q;
  logic [STAGES-1:0][NUM_CH-1:0] chain_d;

  always_comb begin
    chain_d[0] = raw_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/los_flag_bank.sv
module los_flag_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] los_i,
  input  logic              clr_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              int_n_o
);
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] flag_d;
  logic              flag_en;
  logic              int_act_q;
  logic              int_act_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign flag_d[i] = (flag_q[i] & ~clr_i) | los_i[i];
  end

  assign flag_en   = clr_i | (|(los_i & ~flag_q));
  assign int_act_d = |(flag_q & ~mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_act_q <= 1'b0;
    end else begin
      int_act_q <= int_act_d;
    end
  end

  assign flag_o  = flag_q;
  assign int_n_o = ~int_act_q;

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|los_i) |=> ((flag_q & $past(los_i)) == $past(los_i)));

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((flag_q & ~$past(los_i)) == '0));

  p_int_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n_o |-> $past(|(flag_q & ~mask_i)));
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txdis_we,
  input  logic              mask_we,
  input  logic              sqdis_we,
  input  logic [NUM_CH-1:0] txdis_wd,
  input  logic [NUM_CH-1:0] mask_wd,
  input  logic [NUM_CH-1:0] sqdis_wd,
  input  logic [NUM_CH-1:0] los_i,
  output logic [NUM_CH-1:0] txdis_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] sqdis_o,
  output logic [NUM_CH-1:0] rx_squelch_o
);
  logic [NUM_CH-1:0] txdis_q, mask_q, sqdis_q, squelch_q;
  logic [NUM_CH-1:0] squelch_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sq
    assign squelch_d[i] = los_i[i] & ~sqdis_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txdis_q <= '0;
    end else if (txdis_we) begin
      txdis_q <= txdis_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqdis_q <= '0;
    end else if (sqdis_we) begin
      sqdis_q <= sqdis_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      squelch_q <= '0;
    end else begin
      squelch_q <= squelch_d;
    end
  end

  assign txdis_o      = txdis_q;
  assign mask_o       = mask_q;
  assign sqdis_o      = sqdis_q;
  assign rx_squelch_o = squelch_q;

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  p_squelch_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sqdis_we |=> ((rx_squelch_o & sqdis_q) == '0));

  p_txdis_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !txdis_we |=> $stable(txdis_o));
endmodule

// File: rtl/los_irq_ctrl.sv
module los_irq_ctrl
  import los_irq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] los_raw,
  input  logic [7:0]        acc_page,
  input  logic [7:0]        acc_addr,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              int_n,
  output logic [NUM_CH-1:0] tx_disable,
  output logic [NUM_CH-1:0] rx_squelch
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [NUM_CH-1:0]     los_s;
  logic [NUM_CH-1:0]     flags, masks, sqdis;
  logic                  lower_page;
  logic                  sel_status, sel_flags, sel_txdis, sel_mask, sel_sqdis;
  logic                  clr_flags;

  initial begin
    if (NUM_CH > MAX_CH || SYNC_STAGES < 2) begin
      $error("los_irq_ctrl: unsupported parameters");
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  assign lower_page = ~acc_addr[7];
  assign sel_status = lower_page && (acc_addr == ADDR_STATUS);
  assign sel_flags  = lower_page && (acc_addr == ADDR_FLAGS);
  assign sel_txdis  = lower_page && (acc_addr == ADDR_TXDIS);
  assign sel_mask   = lower_page && (acc_addr == ADDR_MASK);
  assign sel_sqdis  = (acc_page == PAGE_SQDIS) && (acc_addr == ADDR_SQDIS);
  assign clr_flags  = acc_rd && sel_flags;

  los_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  (los_raw),
    .sync_o (los_s)
  );

  los_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .los_i   (los_s),
    .clr_i   (clr_flags),
    .mask_i  (masks),
    .flag_o  (flags),
    .int_n_o (int_n)
  );

  chan_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .txdis_we     (acc_wr && sel_txdis),
    .mask_we      (acc_wr && sel_mask),
    .sqdis_we     (acc_wr && sel_sqdis),
    .txdis_wd     (acc_wdata[NUM_CH-1:0]),
    .mask_wd      (acc_wdata[NUM_CH-1:0]),
    .sqdis_wd     (acc_wdata[SQDIS_LSB +: NUM_CH]),
    .los_i        (los_s),
    .txdis_o      (tx_disable),
    .mask_o       (masks),
    .sqdis_o      (sqdis),
    .rx_squelch_o (rx_squelch)
  );

  always_comb begin
    acc_rdata = '0;
    if (sel_status) begin
      acc_rdata[STATUS_INT_BIT] = int_n;
    end else if (sel_flags) begin
      acc_rdata[NUM_CH-1:0] = flags;
    end else if (sel_txdis) begin
      acc_rdata[NUM_CH-1:0] = tx_disable;
    end else if (sel_mask) begin
      acc_rdata[NUM_CH-1:0] = masks;
    end else if (sel_sqdis) begin
      acc_rdata[SQDIS_LSB +: NUM_CH] = sqdis;
    end
  end

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (int_n && (tx_disable == '0) && (rx_squelch == '0)));
endmodule

// File: tb/los_irq_ctrl_tb.sv
module los_irq_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] los_raw;
  logic [7:0] acc_page, acc_addr, acc_wdata, acc_rdata;
  logic       acc_wr, acc_rd, int_n;
  logic [3:0] tx_disable, rx_squelch;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  los_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .los_raw(los_raw), .acc_page(acc_page),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .int_n(int_n),
    .tx_disable(tx_disable), .rx_squelch(rx_squelch)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] p, logic [7:0] a, logic [7:0] d);
    acc_page = p; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic bus_peek(logic [7:0] p, logic [7:0] a, output logic [7:0] d);
    acc_page = p; acc_addr = a;
    #1;
    d = acc_rdata;
  endtask

  task automatic bus_read(logic [7:0] p, logic [7:0] a, output logic [7:0] d);
    acc_page = p; acc_addr = a; acc_rd = 1'b1;
    #1;
    d = acc_rdata;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] rd;
    logic       exp_int_n;
    los_raw = '0; acc_page = '0; acc_addr = '0; acc_wdata = '0;
    acc_wr = 0; acc_rd = 0; rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(5);

    // R11 reset state
    check("R11 int_n", {7'b0, int_n}, 8'h01);
    check("R11 tx_disable", {4'b0, tx_disable}, 8'h00);
    check("R11 rx_squelch", {4'b0, rx_squelch}, 8'h00);
    bus_peek(0, 3, rd);   check("R11 flags", rd, 8'h00);
    bus_peek(0, 100, rd); check("R11 mask", rd, 8'h00);
    bus_peek(3, 240, rd); check("R11 sqdis", rd, 8'h00);
    bus_peek(0, 86, rd);  check("R11 txdis", rd, 8'h00);

    // R1 / R4 / R9 exact latency
    los_raw = 4'b0001;
    tick(2);
    bus_peek(0, 3, rd); check("R1 flag not yet", rd, 8'h00);
    check("R9 squelch not yet", {4'b0, rx_squelch}, 8'h00);
    tick(1);
    bus_peek(0, 3, rd); check("R1 flag at third edge", rd, 8'h01);
    check("R9 squelch at third edge", {4'b0, rx_squelch}, 8'h01);
    check("R4 int_n one edge later", {7'b0, int_n}, 8'h01);
    tick(1);
    check("R4 int_n low", {7'b0, int_n}, 8'h00);
    bus_peek(0, 2, rd); check("R6 soft bit low", rd, 8'h00);

    // R3 re-set while raw still high
    bus_read(0, 3, rd); check("R3 read value", rd, 8'h01);
    bus_peek(0, 3, rd); check("R3 re-set while active", rd, 8'h01);
    los_raw = 4'b0000;
    tick(3);
    bus_read(0, 3, rd); check("R3 read before clear", rd, 8'h01);
    bus_peek(0, 3, rd); check("R3 cleared", rd, 8'h00);
    check("R4 int_n still low one edge", {7'b0, int_n}, 8'h00);
    tick(1);
    check("R4 int_n released", {7'b0, int_n}, 8'h01);
    bus_peek(0, 2, rd); check("R6 soft bit high", rd, 8'h02);

    // R10 writes to 2/3 and stray read strobes
    los_raw = 4'b0011;
    tick(4);
    los_raw = 4'b0000;
    tick(3);
    bus_write(0, 3, 8'h00);
    bus_write(0, 2, 8'hFF);
    bus_read(0, 2, rd);
    bus_read(0, 86, rd);
    bus_read(1, 131, rd);
    bus_peek(0, 3, rd); check("R10 flags kept", rd, 8'h03);
    bus_peek(0, 2, rd); check("R10 byte2 unchanged", rd, 8'h00);
    bus_read(0, 3, rd);
    tick(2);

    // R1 R2 R3 R4 R5 R6 sweep: every mask vs every loss pattern
    for (int m = 0; m < 16; m++) begin
      bus_write(0, 100, 8'(m));
      bus_peek(0, 100, rd); check("R5 mask readback", rd, 8'(m));
      for (int p = 0; p < 16; p++) begin
        exp_int_n = ((p & ~m & 15) == 0);
        los_raw = 4'(p);
        tick(5);
        bus_peek(0, 3, rd); check("R1 flags set", rd, 8'(p));
        check("R4/R5 int_n", {7'b0, int_n}, {7'b0, exp_int_n});
        bus_peek(0, 2, rd); check("R6 soft mirror", rd, {6'b0, exp_int_n, 1'b0});
        los_raw = 4'b0000;
        tick(4);
        bus_peek(0, 3, rd); check("R2 sticky", rd, 8'(p));
        check("R2 int_n held", {7'b0, int_n}, {7'b0, exp_int_n});
        bus_read(0, 3, rd); check("R3 clear-read value", rd, 8'(p));
        tick(1);
        bus_peek(0, 3, rd); check("R3 flags cleared", rd, 8'h00);
        check("R4 int_n released", {7'b0, int_n}, 8'h01);
      end
    end
    bus_write(0, 100, 8'h00);

    // R7 transmit-disable sweep
    for (int t = 0; t < 16; t++) begin
      bus_write(8'(t), 86, {4'hA, 4'(t)});
      check("R7 tx_disable pins", {4'b0, tx_disable}, 8'(t));
      bus_peek(0, 86, rd); check("R7 txdis readback", rd, 8'(t));
    end
    bus_write(0, 86, 8'h00);

    // R8 page decode
    bus_write(3, 240, 8'h50);
    bus_peek(0, 240, rd); check("R8 other page reads 0", rd, 8'h00);
    bus_write(1, 240, 8'hF0);
    bus_peek(3, 240, rd); check("R8 other page write ignored", rd, 8'h50);

    // R8 R9 squelch-disable sweep
    for (int d = 0; d < 16; d++) begin
      bus_write(3, 240, {4'(d), 4'hF});
      bus_peek(3, 240, rd); check("R8 sqdis readback", rd, {4'(d), 4'h0});
      for (int p = 0; p < 16; p++) begin
        los_raw = 4'(p);
        tick(4);
        check("R9 squelch", {4'b0, rx_squelch}, 8'(p & ~d & 15));
        los_raw = 4'b0000;
        tick(4);
        check("R9 squelch off", {4'b0, rx_squelch}, 8'h00);
      end
      bus_read(0, 3, rd);
    end

    report();
  end
endmodule